// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a software-recovery watchdog. It sits off by default after reset. Software turns it on by writing a two-byte key into a write-only service port. Once running, a counter advances on every machine-cycle strobe. Software must write the same key pair again before the counter runs out. If it does not, the watchdog raises a reset request, then drops back to its idle, disabled state.

The reset request is a pulse of fixed length on a drive output, measured in input clocks. A disable input keeps the pin undriven, so it acts as an input only. Two low-power conditions pause the count. A selectable hold stops it while the processor idles. Power-down always stops it. After power-down ends, the count stays frozen while the active-low wake interrupt line is still held low.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is disabled, and `rst_drive` is low. With no key written, no reset pulse ever appears.
- R2: A write of 0x1E to the service port, followed by a write of 0xE1 as the very next service write, enables the watchdog with its count at zero.
- R3: Once enabled, the count advances by one on each clock where `mc_tick` is high and no hold applies. The watchdog overflows on the tick that brings the count to 0x3FFF, which is 16383 ticks after enabling. The pulse is first visible after the clock edge of that tick.
- R4: A completed 0x1E/0xE1 pair written while enabled restarts the count from zero. The key write takes priority over a tick on the same edge.
- R5: On overflow, `rst_drive` is high for exactly 98 consecutive clocks when `rstout_dis` is 0.
- R6: While `rstout_dis` is 1, `rst_drive` stays low, even across an overflow.
- R7: Any service write other than 0xE1 directly after 0x1E abandons the sequence, and a later 0xE1 alone does not enable. A repeated 0x1E re-arms the sequence.
- R8: While `in_idle` is high, `idle_hold` decides the count. At 1 the count freezes. At 0 it keeps counting.
- R9: Overflow clears both the enable and the count. Afterwards no further pulse occurs until the key pair is written again.
- R10: While `pwr_down` is high the count freezes. Once it falls, the count stays frozen for as long as `wake_irq_n` remains low, and counting resumes on the first clock with `wake_irq_n` high.
- R11: The count does not move on clocks where `mc_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mc_tick | input | 1 | One-clock strobe per machine cycle |
| svc_wr | input | 1 | Service-port write strobe |
| svc_data | input | 8 | Service-port write data |
| in_idle | input | 1 | Processor is in idle |
| idle_hold | input | 1 | 1: freeze the count during idle |
| pwr_down | input | 1 | Power-down in effect |
| wake_irq_n | input | 1 | Wake interrupt line, active low |
| rstout_dis | input | 1 | 1: never drive the reset output |
| rst_drive | output | 1 | Reset-out drive, high during the overflow pulse |

## Verification
The checker assumes that `pwr_down`, `in_idle` and `mc_tick` are synchronous to `clk`. It also assumes that a key write and an overflow do not collide while a reset pulse is still running. The stimulus changes every input only on falling edges. It starts a new scenario only after the previous pulse has ended. It re-enables the watchdog only once the pulse is over. Hold and power-down windows are placed well inside an enabled interval, so each frozen span shifts the expected overflow clock by exactly its length.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int          CNT_W_DEF  = 14;
    localparam int          PULSE_DEF  = 98;
    localparam int          DATA_W_DEF = 8;
    localparam logic [7:0]  KEY_A_DEF  = 8'h1E;
    localparam logic [7:0]  KEY_B_DEF  = 8'hE1;

    typedef enum logic [0:0] {
        KEY_WAIT  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_t;
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
    import kwdt_pkg::*;
#(
    parameter int                DATA_W = DATA_W_DEF,
    parameter logic [DATA_W-1:0] KEY_A  = KEY_A_DEF,
    parameter logic [DATA_W-1:0] KEY_B  = KEY_B_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_done
);
    typedef struct packed {
        key_state_t st;
    } ks_t;

    ks_t d, q;

    always_comb begin
        d        = q;
        key_done = 1'b0;
        if (wr_en) begin
            if (q.st == KEY_ARMED && wr_data == KEY_B) begin
                key_done = 1'b1;
                d.st     = KEY_WAIT;
            end else if (wr_data == KEY_A) begin
                d.st = KEY_ARMED;
            end else begin
                d.st = KEY_WAIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: KEY_WAIT};
        else        q <= d;
    end
endmodule

// File: rtl/kwdt_gate.sv
module kwdt_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic pwr_down,
    input  logic wake_irq_n,
    input  logic in_idle,
    input  logic idle_hold,
    output logic count_ok
);
    typedef struct packed {
        logic wake_hold;
    } gs_t;

    gs_t  d, q;
    logic wake_block;

    always_comb begin
        wake_block  = q.wake_hold & ~wake_irq_n;
        d.wake_hold = pwr_down | wake_block;
        count_ok    = mc_tick & ~pwr_down & ~wake_block & ~(in_idle & idle_hold);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_done,
    input  logic             count_ok,
    output logic             enabled,
    output logic             overflow,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_TRIP = {{(CNT_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } cs_t;

    cs_t d, q;

    always_comb begin
        d        = q;
        overflow = 1'b0;
        if (key_done) begin
            d.en  = 1'b1;
            d.cnt = '0;
        end else if (q.en && count_ok) begin
            if (q.cnt == CNT_TRIP) begin
                d.en     = 1'b0;
                d.cnt    = '0;
                overflow = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign enabled = q.en;
    assign count_o = q.cnt;
endmodule

// File: rtl/kwdt_stretch.sv
module kwdt_stretch #(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic drive_dis,
    output logic rst_drive
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } ps_t;

    ps_t d, q;

    always_comb begin
        d = q;
        if (trigger)          d.left = PULSE_LEN[PW-1:0];
        else if (q.left != 0) d.left = q.left - 1'b1;
        rst_drive = (q.left != 0) & ~drive_dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int               CNT_W     = CNT_W_DEF,
    parameter int               PULSE_LEN = PULSE_DEF,
    parameter logic [7:0]       KEY_A     = KEY_A_DEF,
    parameter logic [7:0]       KEY_B     = KEY_B_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mc_tick,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    input  logic       in_idle,
    input  logic       idle_hold,
    input  logic       pwr_down,
    input  logic       wake_irq_n,
    input  logic       rstout_dis,
    output logic       rst_drive
);
    logic             key_w;
    logic             ok_w;
    logic             en_w;
    logic             ovf_w;
    logic [CNT_W-1:0] cnt_w;

    kwdt_keyseq #(.DATA_W(8), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(svc_wr), .wr_data(svc_data),
        .key_done(key_w)
    );

    kwdt_gate u_gate (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .pwr_down(pwr_down),
        .wake_irq_n(wake_irq_n), .in_idle(in_idle), .idle_hold(idle_hold),
        .count_ok(ok_w)
    );

    kwdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .key_done(key_w), .count_ok(ok_w),
        .enabled(en_w), .overflow(ovf_w), .count_o(cnt_w)
    );

    kwdt_stretch #(.PULSE_LEN(PULSE_LEN)) u_out (
        .clk(clk), .rst_n(rst_n), .trigger(ovf_w), .drive_dis(rstout_dis),
        .rst_drive(rst_drive)
    );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mc_tick,
    input logic             in_idle,
    input logic             idle_hold,
    input logic             pwr_down,
    input logic             rstout_dis,
    input logic             rst_drive,
    input logic             key_w,
    input logic             en_w,
    input logic             ovf_w,
    input logic [CNT_W-1:0] cnt_w
);
    a_r2_key_enables: assert property (@(posedge clk) disable iff (!rst_n)
        key_w |=> en_w);

    a_r4_key_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        key_w |=> (cnt_w == '0));

    a_r5_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_w && !rstout_dis) |=> (rst_drive || rstout_dis));

    a_r6_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        rstout_dis |-> !rst_drive);

    a_r8_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && idle_hold && !key_w) |=> $stable(cnt_w));

    a_r9_ovf_disables: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_w |=> (!en_w && cnt_w == '0));

    a_r1_off_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_w && !key_w) |=> (cnt_w == '0));

    a_r10_pd_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !key_w) |=> $stable(cnt_w));

    a_r11_no_tick_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !key_w) |=> $stable(cnt_w));
endmodule

bind keyed_watchdog kwdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .in_idle(in_idle),
    .idle_hold(idle_hold), .pwr_down(pwr_down), .rstout_dis(rstout_dis),
    .rst_drive(rst_drive), .key_w(key_w), .en_w(en_w), .ovf_w(ovf_w),
    .cnt_w(cnt_w)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
    localparam int LIMIT  = 16383;
    localparam int PLEN   = 98;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b1;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       in_idle = 1'b0;
    logic       idle_hold = 1'b0;
    logic       pwr_down = 1'b0;
    logic       wake_irq_n = 1'b1;
    logic       rstout_dis = 1'b0;
    logic       rst_drive;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .svc_wr(svc_wr),
        .svc_data(svc_data), .in_idle(in_idle), .idle_hold(idle_hold),
        .pwr_down(pwr_down), .wake_irq_n(wake_irq_n), .rstout_dis(rstout_dis),
        .rst_drive(rst_drive)
    );

    // behavioural reference
    int m_en = 0, m_cnt = 0, m_arm = 0, m_left = 0, m_hold = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_cnt = 0; m_arm = 0; m_left = 0; m_hold = 0;
        end else begin
            bit keyok, blocked, adv, fired;
            keyok   = svc_wr && m_arm == 1 && svc_data == 8'hE1;
            blocked = pwr_down || (m_hold == 1 && !wake_irq_n) || (in_idle && idle_hold);
            adv     = m_en == 1 && mc_tick && !blocked;
            fired   = 1'b0;
            if (keyok) begin
                m_en = 1; m_cnt = 0;
            end else if (adv) begin
                m_cnt++;
                if (m_cnt == LIMIT) begin
                    m_en = 0; m_cnt = 0; fired = 1'b1;
                end
            end
            if (fired)          m_left = PLEN;
            else if (m_left > 0) m_left--;
            if (svc_wr) m_arm = (!keyok && svc_data == 8'h1E) ? 1 : 0;
            m_hold = (pwr_down || (m_hold == 1 && !wake_irq_n)) ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            bit expv;
            expv = (m_left > 0) && !rstout_dis;
            total++;
            if (rst_drive !== expv) begin
                bad++;
                $display("FAIL %s model compare: rst_drive actual=%0b expected=%0b", cur_req, rst_drive, expv);
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        svc_wr = 1'b1; svc_data = d;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic wait_pulse(output int k);
        k = 0;
        while (!rst_drive && k < 25000) begin
            @(negedge clk); k++;
        end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (rst_drive && n < 300) begin
            n++; @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_drive) seen = 1;
        end
    endtask

    initial begin
        int k, n, s;
        repeat (3) @(negedge clk);
        check("R1 reset drive low", int'(rst_drive), 0);
        rst_n = 1'b1;

        cur_req = "R1";
        quiet(16500, s);
        check("R1 no pulse without key", s, 0);

        cur_req = "R7";
        wr(8'h1E); wr(8'h55); wr(8'hE1);
        quiet(16500, s);
        check("R7 broken key ignored", s, 0);

        cur_req = "R3";
        wr(8'h1E); wr(8'hE1);
        wait_pulse(k);
        check("R2 R3 overflow tick count", k, LIMIT);
        cur_req = "R5";
        pulse_len(n);
        check("R5 pulse length", n, PLEN);
        cur_req = "R9";
        quiet(16500, s);
        check("R9 disabled after overflow", s, 0);

        cur_req = "R4";
        wr(8'h1E); wr(8'h1E); wr(8'hE1);
        repeat (10000) @(negedge clk);
        wr(8'h1E); wr(8'hE1);
        wait_pulse(k);
        check("R4 service restarts count", k, LIMIT);
        check("R7 repeated first key rearms", int'(rst_drive), 1);
        pulse_len(n);
        check("R5 pulse length again", n, PLEN);

        cur_req = "R6";
        rstout_dis = 1'b1;
        wr(8'h1E); wr(8'hE1);
        quiet(16600, s);
        check("R6 no drive when disabled", s, 0);
        rstout_dis = 1'b0;
        quiet(200, s);
        check("R6 no late drive", s, 0);

        cur_req = "R8";
        wr(8'h1E); wr(8'hE1);
        repeat (100) @(negedge clk);
        in_idle = 1'b1; idle_hold = 1'b0;
        repeat (3000) @(negedge clk);
        idle_hold = 1'b1;
        repeat (5000) @(negedge clk);
        in_idle = 1'b0; idle_hold = 1'b0;
        wait_pulse(k);
        check("R8 idle hold delay", 8100 + k, LIMIT + 5000);
        pulse_len(n);

        cur_req = "R10";
        wr(8'h1E); wr(8'hE1);
        repeat (200) @(negedge clk);
        pwr_down = 1'b1;
        repeat (2000) @(negedge clk);
        pwr_down = 1'b0; wake_irq_n = 1'b0;
        repeat (1000) @(negedge clk);
        wake_irq_n = 1'b1;
        cur_req = "R11";
        mc_tick = 1'b0;
        repeat (1000) @(negedge clk);
        mc_tick = 1'b1;
        wait_pulse(k);
        check("R10 R11 frozen spans", 4200 + k, LIMIT + 4000);
        pulse_len(n);
        check("R5 final pulse", n, PLEN);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: run hung actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule